// File: doc/BRIEF.md
# Timed Beep Tone Generator

This block produces a gated square-wave tone for an output amplifier path. After a start, it plays a burst made of a tone interval followed by a silent interval. It then repeats that burst a programmed number of times, stops, and drops its busy flag. Each interval length is an 8-bit code counted in coarse time units. One unit is a fixed number of sample-rate ticks; the default of 384 ticks is 8 ms at 48 kHz. Code n therefore lasts n+1 units.

The pitch comes from a 2-bit select. The select picks a square-wave half period, in sample ticks, from a power-of-two ladder above a base value. The tone appears in two forms: a one-bit level, and a signed full-scale sample that an audio mixer can add.

A sequence starts on the rising edge of the enable input. Clearing the enable aborts the sequence at once. All settings are captured when the sequence starts, so software may rewrite them while a burst is playing.

Top module: `beep_tone_gen`

## Requirements
- R1: While reset is asserted and after its release with enable low, `busy_o` and `tone_bit_o` are 0 and `tone_sample_o` is 0.
- R2: On the first clock edge where `enable_i` is 1 and was 0 at the previous edge, a sequence starts with a tone interval: from the next cycle, `busy_o` is 1 and `tone_bit_o` is 1. A tick present on that start edge is not counted.
- R3: A tone interval lasts exactly (on code + 1) x UNIT_TICKS sample ticks.
- R4: A silent interval lasts exactly (off code + 1) x UNIT_TICKS sample ticks. During it, `busy_o` stays 1, `tone_bit_o` is 0 and `tone_sample_o` is 0.
- R5: During a tone interval, `tone_bit_o` is a square wave with a half period of HALF_BASE x 2^sel sample ticks. Select codes 0, 1, 2 and 3 give factors 1, 2, 4 and 8. The wave starts high at the beginning of every tone interval.
- R6: A repeat code r gives r+1 tone/silent bursts. After the last silent interval, `busy_o` falls to 0 and the output stays silent while enable remains 1. Only a new rising edge of enable starts another sequence.
- R7: When `enable_i` is 0 at a clock edge, the next cycle shows `busy_o` = 0 and silent outputs. This holds even when the same edge would have ended an interval.
- R8: `tone_sample_o` is +(2^(SAMP_W-1)-1) when the tone bit is high in a tone interval. It is -(2^(SAMP_W-1)-1) when the tone bit is low in a tone interval, and 0 at all other times.
- R9: The on, off, repeat and select codes are captured at the start edge. Changing them during a sequence has no effect on that sequence.
- R10: Clock cycles without `tick_i` advance neither the interval timing nor the square wave.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| tick_i | input | 1 | One-cycle sample-rate tick |
| enable_i | input | 1 | Rising edge starts a sequence; low aborts it |
| on_code_i | input | TIME_W | Tone interval length code |
| off_code_i | input | TIME_W | Silent interval length code |
| rpt_code_i | input | RPT_W | Burst count minus one |
| freq_sel_i | input | 2 | Half-period select |
| tone_bit_o | output | 1 | One-bit tone level |
| tone_sample_o | output | SAMP_W | Signed full-scale tone sample |
| busy_o | output | 1 | High from start until the final silent interval ends |

## Verification
Two functions can land on the same clock edge: an abort by clearing enable, and the tick that would end a tone interval and move into the silent one. The bench provokes this directly. It runs a burst with a tick on every cycle until the next tick would close the tone interval. It then drops enable in that same cycle and expects the idle state, not the silent interval, one cycle later. The reference model is a closed-form function of the ticks counted since the start. A second overlap is also covered: a new tone interval can begin on an edge where the square wave would have toggled. This is judged by the wave being high at the start of every burst.

// File: rtl/beep_pkg.sv
package beep_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ON   = 2'd1,
        PH_OFF  = 2'd2,
        PH_DONE = 2'd3
    } beep_phase_e;

    // Half period of the tone in sample ticks for a given select code.
    function automatic int unsigned half_ticks(input int unsigned base, input logic [1:0] sel);
        return base << sel;
    endfunction

endpackage

// File: rtl/beep_unit_timer.sv
module beep_unit_timer #(
    parameter int UNIT_TICKS = 384
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic tick_i,
    input  logic run_i,
    output logic unit_end_o
);
    localparam int UNIT_W = $clog2(UNIT_TICKS + 1);
    localparam logic [UNIT_W-1:0] LAST = UNIT_W'(UNIT_TICKS - 1);

    typedef struct packed {
        logic [UNIT_W-1:0] cnt;
    } timer_t;

    timer_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        unit_end_o = 1'b0;
        if (!run_i) begin
            st_d.cnt = '0;
        end else if (tick_i) begin
            if (st_q.cnt == LAST) begin
                st_d.cnt   = '0;
                unit_end_o = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    AST_UNIT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.cnt <= LAST);                                             // R3
    AST_UNIT_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_i && !tick_i) |=> $stable(st_q.cnt));                     // R10

endmodule

// File: rtl/beep_seq.sv
module beep_seq
    import beep_pkg::*;
#(
    parameter int TIME_W = 8,
    parameter int RPT_W  = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              enable_i,
    input  logic              unit_end_i,
    input  logic [TIME_W-1:0] on_code_i,
    input  logic [TIME_W-1:0] off_code_i,
    input  logic [RPT_W-1:0]  rpt_code_i,
    input  logic [1:0]        sel_i,
    output beep_phase_e       phase_o,
    output logic              active_o,
    output logic              on_entry_o,
    output logic [1:0]        sel_o
);
    typedef struct packed {
        beep_phase_e       phase;
        logic [TIME_W-1:0] intv;
        logic [RPT_W-1:0]  rpt;
        logic [TIME_W-1:0] on_lat;
        logic [TIME_W-1:0] off_lat;
        logic [RPT_W-1:0]  rpt_lat;
        logic [1:0]        sel_lat;
        logic              en;
    } seq_t;

    seq_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        on_entry_o = 1'b0;
        st_d.en    = enable_i;
        if (!enable_i) begin
            st_d.phase = PH_IDLE;
            st_d.intv  = '0;
            st_d.rpt   = '0;
        end else if (!st_q.en) begin
            st_d.phase   = PH_ON;
            st_d.intv    = '0;
            st_d.rpt     = '0;
            st_d.on_lat  = on_code_i;
            st_d.off_lat = off_code_i;
            st_d.rpt_lat = rpt_code_i;
            st_d.sel_lat = sel_i;
            on_entry_o   = 1'b1;
        end else begin
            unique case (st_q.phase)
                PH_ON: begin
                    if (unit_end_i) begin
                        if (st_q.intv == st_q.on_lat) begin
                            st_d.phase = PH_OFF;
                            st_d.intv  = '0;
                        end else begin
                            st_d.intv = st_q.intv + 1'b1;
                        end
                    end
                end
                PH_OFF: begin
                    if (unit_end_i) begin
                        if (st_q.intv == st_q.off_lat) begin
                            st_d.intv = '0;
                            if (st_q.rpt == st_q.rpt_lat) begin
                                st_d.phase = PH_DONE;
                            end else begin
                                st_d.rpt   = st_q.rpt + 1'b1;
                                st_d.phase = PH_ON;
                                on_entry_o = 1'b1;
                            end
                        end else begin
                            st_d.intv = st_q.intv + 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '{phase: PH_IDLE, default: '0};
        else         st_q <= st_d;
    end

    assign phase_o  = st_q.phase;
    assign active_o = enable_i && st_q.en && (st_q.phase == PH_ON || st_q.phase == PH_OFF);
    assign sel_o    = st_q.sel_lat;

    AST_START_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (enable_i && !st_q.en) |=> (st_q.phase == PH_ON));             // R2
    AST_ABORT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !enable_i |=> (st_q.phase == PH_IDLE));                         // R7
    AST_ON_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.phase == PH_ON) |-> (st_q.intv <= st_q.on_lat));         // R3
    AST_OFF_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.phase == PH_OFF) |-> (st_q.intv <= st_q.off_lat));       // R4
    AST_RPT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.phase != PH_IDLE) |-> (st_q.rpt <= st_q.rpt_lat));       // R6
    AST_DONE_STAYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.phase == PH_DONE && enable_i) |=> (st_q.phase == PH_DONE)); // R6
    AST_LATCH_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (enable_i && st_q.en) |=> $stable(st_q.on_lat) && $stable(st_q.sel_lat)); // R9

endmodule

// File: rtl/beep_square.sv
module beep_square #(
    parameter int HALF_BASE = 6
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       tick_i,
    input  logic       run_i,
    input  logic       restart_i,
    input  logic [1:0] sel_i,
    output logic       level_o
);
    localparam int HALF_MAX = HALF_BASE << 3;
    localparam int HALF_W   = $clog2(HALF_MAX + 1);

    typedef struct packed {
        logic [HALF_W-1:0] cnt;
        logic              lvl;
    } sq_t;

    sq_t               st_d, st_q;
    logic [HALF_W-1:0] half_m1;

    always_comb begin
        half_m1 = HALF_W'(beep_pkg::half_ticks(HALF_BASE, sel_i) - 1);
        st_d    = st_q;
        if (restart_i) begin
            st_d.cnt = '0;
            st_d.lvl = 1'b1;
        end else if (run_i && tick_i) begin
            if (st_q.cnt == half_m1) begin
                st_d.cnt = '0;
                st_d.lvl = ~st_q.lvl;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign level_o = st_q.lvl;

    AST_ENTRY_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        restart_i |=> st_q.lvl);                                        // R5
    AST_LVL_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!restart_i && !tick_i) |=> $stable(st_q.lvl));                 // R10
    AST_HALF_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        run_i |-> (st_q.cnt <= half_m1));                               // R5

endmodule

// File: rtl/beep_tone_gen.sv
module beep_tone_gen
    import beep_pkg::*;
#(
    parameter int UNIT_TICKS = 384,
    parameter int HALF_BASE  = 6,
    parameter int TIME_W     = 8,
    parameter int RPT_W      = 4,
    parameter int SAMP_W     = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic              enable_i,
    input  logic [TIME_W-1:0] on_code_i,
    input  logic [TIME_W-1:0] off_code_i,
    input  logic [RPT_W-1:0]  rpt_code_i,
    input  logic [1:0]        freq_sel_i,
    output logic              tone_bit_o,
    output logic [SAMP_W-1:0] tone_sample_o,
    output logic              busy_o
);
    localparam logic [SAMP_W-1:0] POS_FS = {1'b0, {(SAMP_W-1){1'b1}}};
    localparam logic [SAMP_W-1:0] NEG_FS = {1'b1, {(SAMP_W-2){1'b0}}, 1'b1};

    beep_phase_e phase;
    logic        active, on_entry, unit_end, level;
    logic [1:0]  sel_lat;

    beep_unit_timer #(.UNIT_TICKS(UNIT_TICKS)) u_timer (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .tick_i     (tick_i),
        .run_i      (active),
        .unit_end_o (unit_end)
    );

    beep_seq #(.TIME_W(TIME_W), .RPT_W(RPT_W)) u_seq (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .enable_i   (enable_i),
        .unit_end_i (unit_end),
        .on_code_i  (on_code_i),
        .off_code_i (off_code_i),
        .rpt_code_i (rpt_code_i),
        .sel_i      (freq_sel_i),
        .phase_o    (phase),
        .active_o   (active),
        .on_entry_o (on_entry),
        .sel_o      (sel_lat)
    );

    beep_square #(.HALF_BASE(HALF_BASE)) u_square (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .tick_i    (tick_i),
        .run_i     (phase == PH_ON),
        .restart_i (on_entry),
        .sel_i     (sel_lat),
        .level_o   (level)
    );

    always_comb begin
        busy_o        = (phase == PH_ON) || (phase == PH_OFF);
        tone_bit_o    = (phase == PH_ON) && level;
        tone_sample_o = '0;
        if (phase == PH_ON) tone_sample_o = level ? POS_FS : NEG_FS;
    end

    AST_SILENT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_o |-> (tone_sample_o == '0) && !tone_bit_o);              // R8
    AST_BIT_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tone_bit_o |-> (tone_sample_o == POS_FS));                      // R8

endmodule

// File: tb/beep_tone_gen_tb.sv
`timescale 1ns/1ps
module beep_tone_gen_tb;
    localparam int U      = 4;
    localparam int HB     = 2;
    localparam int RW     = 3;
    localparam int SW     = 16;
    localparam int FS     = 32767;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick = 1'b0;
    logic          en = 1'b0;
    logic [7:0]    on_c = '0, off_c = '0;
    logic [RW-1:0] rpt_c = '0;
    logic [1:0]    sel_c = '0;
    logic          tone_bit, busy;
    logic [SW-1:0] sample;

    int checks = 0, fails = 0;
    int k = 0;
    bit running = 0, prev_en = 0;
    int l_on, l_off, l_rpt, l_sel;

    always #2 clk = ~clk;

    beep_tone_gen #(.UNIT_TICKS(U), .HALF_BASE(HB), .TIME_W(8), .RPT_W(RW), .SAMP_W(SW)) u_dut (
        .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .enable_i(en),
        .on_code_i(on_c), .off_code_i(off_c), .rpt_code_i(rpt_c), .freq_sel_i(sel_c),
        .tone_bit_o(tone_bit), .tone_sample_o(sample), .busy_o(busy));

    function automatic int t_on();  return (l_on + 1) * U;  endfunction
    function automatic int t_per(); return (l_on + 1) * U + (l_off + 1) * U; endfunction
    function automatic int t_all(); return t_per() * (l_rpt + 1); endfunction

    function automatic bit exp_busy();
        return running && (k < t_all());
    endfunction
    function automatic bit exp_on();
        return exp_busy() && ((k % t_per()) < t_on());
    endfunction
    function automatic bit exp_bit();
        return exp_on() && ((((k % t_per()) / (HB << l_sel)) % 2) == 0);
    endfunction
    function automatic int exp_sample();
        if (!exp_on()) return 0;
        return exp_bit() ? FS : -FS;
    endfunction

    task automatic check_out(input string tag);
        int act_s;
        act_s = int'($signed(sample));
        checks++;
        if (busy !== exp_busy()) begin
            fails++;
            $display("FAIL %s busy: actual %0b expected %0b (k=%0d)", tag, busy, exp_busy(), k);
        end
        checks++;
        if (tone_bit !== exp_bit()) begin
            fails++;
            $display("FAIL %s tone_bit: actual %0b expected %0b (k=%0d)", tag, tone_bit, exp_bit(), k);
        end
        checks++;
        if (act_s != exp_sample()) begin
            fails++;
            $display("FAIL R8 %s sample: actual %0d expected %0d (k=%0d)", tag, act_s, exp_sample(), k);
        end
    endtask

    task automatic step(input logic tk, input string tag);
        tick = tk;
        @(posedge clk);
        if (!en) running = 0;
        else if (!prev_en) begin
            running = 1; k = 0;
            l_on = on_c; l_off = off_c; l_rpt = rpt_c; l_sel = sel_c;
        end else if (running && tk) k++;
        prev_en = en;
        @(negedge clk);
        check_out(tag);
    endtask

    task automatic start(input int on, input int off, input int rp, input int sl, input string tag);
        en = 0; step(1'b1, tag);
        on_c = 8'(on); off_c = 8'(off); rpt_c = RW'(rp); sel_c = 2'(sl);
        en = 1; step(1'b1, tag);
    endtask

    // tick_pct: probability of a tick in percent; scramble: rewrite codes each cycle
    task automatic run_out(input int tick_pct, input bit scramble, input int extra, input string tag);
        int guard = 0;
        while (exp_busy() && guard < 20000) begin
            if (scramble) begin
                on_c = 8'($urandom); off_c = 8'($urandom);
                rpt_c = RW'($urandom); sel_c = 2'($urandom);
            end
            step(($urandom_range(0, 99) < tick_pct) ? 1'b1 : 1'b0, tag);
            guard++;
        end
        for (int i = 0; i < extra; i++) step(1'b1, tag);
    endtask

    initial begin
        repeat (2000000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20250611));
        l_on = 0; l_off = 0; l_rpt = 0; l_sel = 0;
        repeat (3) @(negedge clk);
        check_out("R1 in reset");
        rst_n = 1;
        for (int i = 0; i < 3; i++) step(1'b1, "R1 after reset");

        // Shortest burst, tick each cycle
        start(0, 0, 0, 0, "R2 start");
        run_out(100, 0, 3, "R3 R4 R5 short");

        // Sparse ticks
        start(1, 2, 1, 1, "R10 start");
        run_out(30, 0, 3, "R10 sparse ticks");

        // Every select code
        for (int s = 0; s < 4; s++) begin
            start(3, 1, 1, s, "R5 select");
            run_out(100, 0, 2, "R5 select run");
        end

        // Maximum repeat, then hold enable high in done state
        start(0, 1, 7, 0, "R6 start");
        run_out(80, 0, 10, "R6 max repeat and hold");

        // Long tone interval
        start(255, 0, 0, 3, "R3 long");
        run_out(100, 0, 2, "R3 long run");

        // Abort on the tick that would close the tone interval
        start(1, 0, 2, 0, "R7 start");
        while (k < t_on() - 1) step(1'b1, "R7 pre");
        en = 0;
        step(1'b1, "R7 abort at boundary");
        for (int i = 0; i < 3; i++) step(1'b1, "R7 idle");

        // Random sequences with codes rewritten mid-sequence
        for (int s = 0; s < 12; s++) begin
            start($urandom_range(0, 5), $urandom_range(0, 5), $urandom_range(0, 3),
                  $urandom_range(0, 3), "R9 random start");
            run_out($urandom_range(20, 100), 1, 2, "R9 R4 random run");
        end

        en = 0; step(1'b0, "R7 final");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule